// File: doc/BRIEF.md
# Step Attenuator Control Core

This block is the digital control core of a 5-bit RF step attenuator with 0.25 dB steps. It produces a registered 5-bit attenuation code for the analog switch array. It takes that code from one of three programming paths.

- **Direct-parallel:** the parallel control pins pass straight through while the latch strobe is high.
- **Latched-parallel:** the parallel pins are captured by a high-then-low pulse on the latch strobe.
- **Serial-addressable:** a 16-bit frame is shifted in on a serial clock. It is committed on a rising latch strobe, but only if the frame's embedded address matches the three strapped chip-address pins.

All logic runs on one system clock. The serial clock, serial data and latch strobe are asynchronous to it. Each of them passes through a two-flop synchronizer, and edges are found on the synchronized copies. Reset stands in for power-up. After reset the code sits at maximum attenuation for a programmable hold window, then follows whichever path is active. A matched frame that sets any of the reserved attenuation bits raises an error flag and leaves the setting unchanged.

Top module: `step_atten_ctrl`

## Requirements
- R1: `ser_mode_i` = 0 selects the parallel paths and 1 selects the serial path. While it is 1, changes on `par_code_i` never reach `atten_o`.
- R2: In parallel mode, every cycle in which the synchronized strobe is high loads `par_code_i` into `atten_o`. The code is weighted 4, 2, 1, 0.5 and 0.25 dB from bit 4 down to bit 0, and 0 is the insertion-loss state.
- R3: In parallel mode, while the synchronized strobe is low, `atten_o` holds the value loaded in the last cycle the strobe was high. Pin changes during that time have no effect.
- R4: The serial frame is shifted in LSB first, one bit per rising edge of the synchronized serial clock. Bits 4..0 carry the code, bits 7..5 are reserved and must be 0, bits 10..8 carry the address, and bits 15..11 are ignored. A rising edge of the synchronized strobe commits the frame.
- R5: Shifting serial bits while the strobe stays low never changes `atten_o`.
- R6: While reset is asserted, `atten_o` is 31 (7.75 dB) and `frame_err_o` is 0.
- R7: For `HOLD_CYCLES` cycles after reset is released internally, `atten_o` stays 31 and no path may change it.
- R8: A committed frame whose bits 10..8 differ from `chip_addr_i` changes neither `atten_o` nor `frame_err_o`.
- R9: A committed, address-matched frame with any of bits 7..5 set sets `frame_err_o` to 1 and keeps `atten_o`. A matched frame with those bits clear loads the code and clears `frame_err_o`.

Requirements R3 and R5 depend on the strobe being low; the serial and parallel rules above cover every case in which it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ser_mode_i | input | 1 | 0 = parallel paths, 1 = serial path |
| par_code_i | input | 5 | Parallel attenuation code |
| le_i | input | 1 | Latch strobe, asynchronous |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| chip_addr_i | input | 3 | Strapped chip address |
| atten_o | output | 5 | Registered attenuation code to the switch array |
| frame_err_o | output | 1 | Last matched frame had reserved bits set |

## Verification
The strobe, serial clock and serial data each cross two synchronizer flops and one edge register. A change on any of them therefore shows up on `atten_o` at the third rising system-clock edge. While the strobe is already high, a parallel pin change shows up after one edge. The bench drives inputs on falling edges and waits at least four cycles after each stimulus before it queues an expected value. The monitor compares that value on a later falling edge, and no input moves until the comparison is done. The hold-window checks add two edges for the internal reset synchronizer. One check is placed well inside the window and one well after it.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } sa_mode_e;
endpackage

// File: rtl/sa_sync.sv
`timescale 1ns/1ps
module sa_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] src;
      if (g == 0) begin : g_first
        assign src = d_i;
      end else begin : g_rest
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sa_shifter.sv
`timescale 1ns/1ps
module sa_shifter #(
  parameter int FRAME_W = 16,
  parameter int KEEP_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [KEEP_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {bit_i, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign frame_o = sh_q[KEEP_W-1:0];
endmodule

// File: rtl/sa_hold_timer.sv
`timescale 1ns/1ps
module sa_hold_timer #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy_o
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy_o = (cnt_q != LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (busy_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/step_atten_ctrl.sv
`timescale 1ns/1ps
module step_atten_ctrl
  import sa_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int WORD_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode_i,
  input  logic [CODE_W-1:0] par_code_i,
  input  logic              le_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [ADDR_W-1:0] chip_addr_i,
  output logic [CODE_W-1:0] atten_o,
  output logic              frame_err_o
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int KEEP_W  = WORD_W + ADDR_W;
  localparam int PAD_W   = WORD_W - CODE_W;

  // internal reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // synchronize strobe, serial clock and serial data
  logic le_s, sclk_s, sdata_s;
  sa_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   ({le_i, sclk_i, sdata_i}),
    .q_o   ({le_s, sclk_s, sdata_s})
  );

  logic le_d, sclk_d;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      le_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      le_d   <= le_s;
      sclk_d <= sclk_s;
    end
  end

  logic le_rise, sclk_rise;
  assign le_rise   = le_s & ~le_d;
  assign sclk_rise = sclk_s & ~sclk_d;

  logic [KEEP_W-1:0] frame;
  sa_shifter #(.FRAME_W(FRAME_W), .KEEP_W(KEEP_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_en (sclk_rise),
    .bit_i    (sdata_s),
    .frame_o  (frame)
  );

  logic pup_busy;
  sa_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .busy_o (pup_busy)
  );

  logic addr_hit, pad_bad;
  assign addr_hit = (frame[WORD_W +: ADDR_W] == chip_addr_i);
  assign pad_bad  = |frame[CODE_W +: PAD_W];

  logic [CODE_W-1:0] atten_q, atten_d;
  logic              err_q, err_d;

  always_comb begin
    atten_d = atten_q;
    err_d   = err_q;
    if (!pup_busy) begin
      if (sa_mode_e'(ser_mode_i) == MODE_SER) begin
        if (le_rise && addr_hit) begin
          if (pad_bad) begin
            err_d = 1'b1;
          end else begin
            atten_d = frame[CODE_W-1:0];
            err_d   = 1'b0;
          end
        end
      end else if (le_s) begin
        atten_d = par_code_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      atten_q <= '1;
      err_q   <= 1'b0;
    end else begin
      atten_q <= atten_d;
      err_q   <= err_d;
    end
  end

  assign atten_o     = atten_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/sa_ctrl_chk.sv
`timescale 1ns/1ps
module sa_ctrl_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_mode_i,
  input logic              le_s,
  input logic              le_rise,
  input logic              addr_hit,
  input logic              pup_busy,
  input logic [CODE_W-1:0] atten_o,
  input logic              frame_err_o
);
  // R3 / R5: the code can only move while the synchronized strobe is high
  p_strobe_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(atten_o));

  // R7: hold window pins the maximum setting
  p_hold_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pup_busy |-> (&atten_o));

  // R8: a frame for another address leaves both outputs alone
  p_addr_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode_i && le_rise && !addr_hit) |=> ($stable(atten_o) && $stable(frame_err_o)));

  // R9: raising the error flag never comes with a code change
  p_err_keeps_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err_o) |-> $stable(atten_o));

  // R9: the flag only moves after a serial commit
  p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(frame_err_o) |-> $past(le_rise && ser_mode_i));
endmodule

bind step_atten_ctrl sa_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .ser_mode_i  (ser_mode_i),
  .le_s        (le_s),
  .le_rise     (le_rise),
  .addr_hit    (addr_hit),
  .pup_busy    (pup_busy),
  .atten_o     (atten_o),
  .frame_err_o (frame_err_o)
);

// File: tb/test_step_atten_ctrl.sv
`timescale 1ns/1ps
module test_step_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_mode;
  logic [4:0] par_code;
  logic       le;
  logic       sclk;
  logic       sdata;
  logic [2:0] chip_addr;
  logic [4:0] atten;
  logic       ferr;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  step_atten_ctrl #(.HOLD_CYCLES(20)) i_step_atten_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_mode_i  (ser_mode),
    .par_code_i  (par_code),
    .le_i        (le),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .chip_addr_i (chip_addr),
    .atten_o     (atten),
    .frame_err_o (ferr)
  );

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({ferr, atten} !== e) begin
        failures++;
        $display("FAIL %s: actual code=%0d err=%0b expected code=%0d err=%0b",
                 t, atten, ferr, e[4:0], e[5]);
      end
    end
  end

  task automatic expect_out(input logic [4:0] code, input logic err, input string tag);
    exp_q.push_back({err, code});
    tag_q.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] fr, input logic [4:0] hold_code,
                            input logic hold_err);
    for (int i = 0; i < 16; i++) begin
      sdata = fr[i];
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(3);
      sclk = 1'b0;
      wait_cyc(3);
      if (i == 8) expect_out(hold_code, hold_err, "R5 shifting with strobe low");
    end
    wait_cyc(2);
    le = 1'b1;
    wait_cyc(4);
    le = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    ser_mode  = 1'b0;
    par_code  = 5'd5;
    le        = 1'b1;
    sclk      = 1'b0;
    sdata     = 1'b0;
    chip_addr = 3'b101;
    wait_cyc(4);
    expect_out(5'd31, 1'b0, "R6 reset state");
    rst_n = 1'b1;
    wait_cyc(6);
    expect_out(5'd31, 1'b0, "R7 inside hold window");
    wait_cyc(30);
    expect_out(5'd5, 1'b0, "R7 after hold window");

    // direct-parallel following
    par_code = 5'd18;
    wait_cyc(4);
    expect_out(5'd18, 1'b0, "R2 direct follow");
    par_code = 5'd0;
    wait_cyc(4);
    expect_out(5'd0, 1'b0, "R2 insertion-loss state");

    // latched-parallel
    le = 1'b0;
    wait_cyc(5);
    par_code = 5'd9;
    wait_cyc(5);
    expect_out(5'd0, 1'b0, "R3 strobe low ignores pins");
    le = 1'b1;
    wait_cyc(3);
    le = 1'b0;
    wait_cyc(5);
    expect_out(5'd9, 1'b0, "R3 latched by pulse");
    par_code = 5'd3;
    wait_cyc(5);
    expect_out(5'd9, 1'b0, "R3 hold after pulse");

    // serial-addressable
    ser_mode = 1'b1;
    par_code = 5'd22;
    wait_cyc(5);
    expect_out(5'd9, 1'b0, "R1 serial mode ignores pins");
    send_frame({8'hFD, 8'h0F}, 5'd9, 1'b0);
    expect_out(5'd15, 1'b0, "R4 matched frame, upper address ignored");
    send_frame({8'hFC, 8'h07}, 5'd15, 1'b0);
    expect_out(5'd15, 1'b0, "R8 address mismatch");
    send_frame({8'h05, 8'h27}, 5'd15, 1'b0);
    expect_out(5'd15, 1'b1, "R9 reserved bit set");
    send_frame({8'h04, 8'h01}, 5'd15, 1'b1);
    expect_out(5'd15, 1'b1, "R8 mismatch keeps flag");
    send_frame({8'h05, 8'h00}, 5'd15, 1'b1);
    expect_out(5'd0, 1'b0, "R9 clean frame clears flag");
    send_frame({8'hAD, 8'h1F}, 5'd0, 1'b0);
    expect_out(5'd31, 1'b0, "R4 maximum code");

    // back to parallel
    ser_mode = 1'b0;
    par_code = 5'd12;
    wait_cyc(2);
    le = 1'b1;
    wait_cyc(5);
    expect_out(5'd12, 1'b0, "R1 parallel mode restored");

    wait_cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule